// File: doc/BRIEF.md
# Coprocessor Host Control Window

This block is the host-facing register window of a coprocessor. The host issues byte reads and byte writes. The block decodes each access and holds the control state that the coprocessor's engines consume: the transfer source, destination and length, the program cache base and page, the cache lock bits, the program bank and counter, and the memory wait-state settings. It also holds sixteen 24-bit general registers, a 32-byte vector area and a data RAM byte array.

Some writes have side effects. A write to the last byte of the transfer destination, to the cache page select or to the program counter starts the matching engine through a one-cycle strobe. Each of these starts only while the coprocessor is stopped. A group of addresses arms a timed suspend whose length is taken from the address. Other addresses cancel the suspend, clear the interrupt flag or release the lock. The transfer engine, the cache filler and the instruction core lie outside this block. They reach it through busy, halt, lock and interrupt inputs, and the status byte is assembled live from those inputs.

Every read returns its byte on `rdata_o` one clock after `rd_en_i`.

Top module: `cop_host_regs`

## Requirements
- R1: Only the low 12 bits of `addr_i` select a location (offset). Offsets 0x000–0xBFF are a data RAM byte array. Every read presents its byte on `rdata_o` in the cycle after `rd_en_i` is sampled.
- R2: Offsets 0xF60–0xF7F form a 32-byte vector area that can be read and written. It resets to 0x00.
- R3: Offsets 0x80–0xAF and 0xC0–0xEF (both windows at 0xF00 + x) alias sixteen 24-bit registers. With o = offset & 0x3F, the register index is o/3 and the byte lane is o%3, where lane 0 is the least significant byte. The registers reset to zero.
- R4: A read of any offset from 0xF53 to 0xF5F returns the status byte. The bits are:
  - bit 0: suspend active.
  - bit 1: interrupt flag.
  - bit 6: running, which is busy OR not stopped.
  - bit 7: busy, which is the OR of the three busy inputs.
  - All other bits are 0.
- R5: A write to offset 0xF55+k (k = 0..7) arms the suspend with a length of 32·k cycles. For k>0, `suspend_o` stays high for exactly 32·k cycles after the write edge and then clears by itself. For k=0, it stays high until cancelled.
- R6: A write to 0xF5D cancels the suspend. A write to 0xF5E clears the interrupt flag. `irq_set_i` sets the flag and wins over a clear in the same cycle.
- R7: Offset 0xF50 holds the RAM wait states in bits 2:0 and the ROM wait states in bits 6:4. It resets to 0x33.
- R8: Strobes appear the cycle after the write, and only if the coprocessor was stopped:
  - A write to 0xF47 pulses `dma_start_o`.
  - A write to 0xF48 stores the cache page from bit 0 and pulses `cache_start_o`.
  - A write to 0xF4F stores the program counter, pulses `exec_start_o` and clears `stopped_o`.
- R9: The program bank high byte at 0xF4E keeps only bits 6:0. A write to 0xF51 stores the interrupt disable from bit 0; when that bit is 1, the interrupt flag is set.
- R10: A write to 0xF53 clears `locked_o` and sets `stopped_o`, and it has priority over `lock_req_i`. `lock_req_i` sets the lock. `core_halt_i` sets `stopped_o`. Reset leaves the block stopped, unlocked, with the single-ROM flag 1.
- R11: Unmapped offsets (0xC00–0xF3F, 0xFB0–0xFBF, 0xFF0–0xFFF) read back as 0x00 and ignore writes. Status-window writes other than the offsets named in R5, R6 and R10 have no effect.
- R12: The control bytes read back as written, least significant byte first:
  - Transfer source at 0xF40–0xF42, length at 0xF43–0xF44, destination at 0xF45–0xF47.
  - Page at 0xF48, cache base at 0xF49–0xF4B, lock bits 1:0 at 0xF4C.
  - Program bank at 0xF4D–0xF4E, program counter at 0xF4F.
  - Interrupt disable bit 0 at 0xF51, single-ROM bit 0 at 0xF52.
  - The same values drive the matching output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host byte write enable |
| rd_en_i | input | 1 | Host byte read enable |
| addr_i | input | HOST_AW | Host address; only bits 11:0 decoded |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Read byte, valid the cycle after a read |
| dma_busy_i | input | 1 | Transfer engine busy |
| cache_busy_i | input | 1 | Cache filler busy |
| bus_busy_i | input | 1 | Bus access delay pending |
| core_halt_i | input | 1 | Core requests stopped state |
| lock_req_i | input | 1 | Engine reports an invalid transfer; lock |
| irq_set_i | input | 1 | Core raises the interrupt flag |
| dma_src_o | output | XA_W | Transfer source address |
| dma_len_o | output | LEN_W | Transfer length |
| dma_dst_o | output | XA_W | Transfer destination address |
| cache_base_o | output | XA_W | Program cache base address |
| cache_page_o | output | 1 | Selected cache page |
| cache_lock_o | output | 2 | Per-page cache lock |
| prog_bank_o | output | BANK_W | Program bank |
| prog_ctr_o | output | PC_W | Program counter start value |
| ram_dly_o | output | DLY_W | RAM wait states |
| rom_dly_o | output | DLY_W | ROM wait states |
| irq_dis_o | output | 1 | Interrupt disable |
| single_rom_o | output | 1 | Single-ROM flag |
| stopped_o | output | 1 | Coprocessor stopped |
| locked_o | output | 1 | Coprocessor locked |
| suspend_o | output | 1 | Suspend active |
| irq_flag_o | output | 1 | Interrupt flag |
| dma_start_o | output | 1 | One-cycle transfer start strobe |
| cache_start_o | output | 1 | One-cycle cache fill strobe |
| exec_start_o | output | 1 | One-cycle execution start strobe |

## Verification
Errors in the stopped or lock state show up one cycle after the write that should have changed them. They appear as a missing or spurious start strobe and through bit 6 of the next status read. A suspend counter that loads or counts wrongly moves the falling edge of `suspend_o` away from exactly 32·k cycles, so the error is visible within at most 224 cycles. Errors in register-file lane selection or window aliasing stay hidden until the aliased byte is read back. For that reason the random traffic mixes both windows with RAM and vector accesses and compares every read against a model.

// File: rtl/cop_host_pkg.sv
`timescale 1ns/1ps
package cop_host_pkg;
  typedef enum logic [2:0] {
    RG_NONE, RG_DRAM, RG_VEC, RG_GPR, RG_STAT, RG_CTRL
  } region_e;

  localparam logic [11:0] OFF_CTRL_LO  = 12'hF40;
  localparam logic [11:0] OFF_CTRL_HI  = 12'hF52;
  localparam logic [11:0] OFF_SRC0     = 12'hF40;
  localparam logic [11:0] OFF_SRC1     = 12'hF41;
  localparam logic [11:0] OFF_SRC2     = 12'hF42;
  localparam logic [11:0] OFF_LEN0     = 12'hF43;
  localparam logic [11:0] OFF_LEN1     = 12'hF44;
  localparam logic [11:0] OFF_DST0     = 12'hF45;
  localparam logic [11:0] OFF_DST1     = 12'hF46;
  localparam logic [11:0] OFF_DST2     = 12'hF47;
  localparam logic [11:0] OFF_PAGE     = 12'hF48;
  localparam logic [11:0] OFF_CBASE0   = 12'hF49;
  localparam logic [11:0] OFF_CBASE1   = 12'hF4A;
  localparam logic [11:0] OFF_CBASE2   = 12'hF4B;
  localparam logic [11:0] OFF_LOCK     = 12'hF4C;
  localparam logic [11:0] OFF_BANK0    = 12'hF4D;
  localparam logic [11:0] OFF_BANK1    = 12'hF4E;
  localparam logic [11:0] OFF_PC       = 12'hF4F;
  localparam logic [11:0] OFF_WAIT     = 12'hF50;
  localparam logic [11:0] OFF_IRQDIS   = 12'hF51;
  localparam logic [11:0] OFF_SROM     = 12'hF52;
  localparam logic [11:0] OFF_STAT_LO  = 12'hF53;
  localparam logic [11:0] OFF_STAT_HI  = 12'hF5F;
  localparam logic [11:0] OFF_UNLOCK   = 12'hF53;
  localparam logic [11:0] OFF_ARM_LO   = 12'hF55;
  localparam logic [11:0] OFF_ARM_HI   = 12'hF5C;
  localparam logic [11:0] OFF_CANCEL   = 12'hF5D;
  localparam logic [11:0] OFF_IRQCLR   = 12'hF5E;
  localparam logic [11:0] OFF_VEC_LO   = 12'hF60;
  localparam logic [11:0] OFF_VEC_HI   = 12'hF7F;
  localparam logic [11:0] OFF_GPRA_LO  = 12'hF80;
  localparam logic [11:0] OFF_GPRA_HI  = 12'hFAF;
  localparam logic [11:0] OFF_GPRB_LO  = 12'hFC0;
  localparam logic [11:0] OFF_GPRB_HI  = 12'hFEF;

  localparam logic [2:0] WAIT_RESET = 3'd3;
endpackage

// File: rtl/cop_addr_decode.sv
`timescale 1ns/1ps
module cop_addr_decode
  import cop_host_pkg::*;
#(
  parameter int DRAM_DEPTH = 3072,
  parameter int GPR_N      = 16,
  parameter int VEC_N      = 32,
  localparam int GIW       = $clog2(GPR_N),
  localparam int VIW       = $clog2(VEC_N)
) (
  input  logic [11:0]    off_i,
  output region_e        region_o,
  output logic [GIW-1:0] gpr_idx_o,
  output logic [1:0]     gpr_lane_o,
  output logic [VIW-1:0] vec_idx_o
);
  logic [5:0] gofs;

  assign gofs       = off_i[5:0];
  assign gpr_idx_o  = GIW'(gofs / 6'd3);
  assign gpr_lane_o = 2'(gofs % 6'd3);
  assign vec_idx_o  = off_i[VIW-1:0];

  always_comb begin
    if (32'(off_i) < DRAM_DEPTH)                             region_o = RG_DRAM;
    else if (off_i >= OFF_VEC_LO && off_i <= OFF_VEC_HI)     region_o = RG_VEC;
    else if ((off_i >= OFF_GPRA_LO && off_i <= OFF_GPRA_HI) ||
             (off_i >= OFF_GPRB_LO && off_i <= OFF_GPRB_HI)) region_o = RG_GPR;
    else if (off_i >= OFF_STAT_LO && off_i <= OFF_STAT_HI)   region_o = RG_STAT;
    else if (off_i >= OFF_CTRL_LO && off_i <= OFF_CTRL_HI)   region_o = RG_CTRL;
    else                                                     region_o = RG_NONE;
  end
endmodule

// File: rtl/cop_gpr_file.sv
`timescale 1ns/1ps
module cop_gpr_file #(
  parameter int GPR_N = 16,
  parameter int GPR_W = 24,
  localparam int GIW  = $clog2(GPR_N),
  localparam int LANES = GPR_W / 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [GIW-1:0] idx_i,
  input  logic [1:0]     lane_i,
  input  logic [7:0]     wdata_i,
  output logic [7:0]     rdata_o
);
  logic [GPR_W-1:0] words [GPR_N];

  for (genvar r = 0; r < GPR_N; r++) begin : g_reg
    logic [GPR_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (we_i && idx_i == GIW'(r)) begin
        for (int l = 0; l < LANES; l++) begin
          if (lane_i == 2'(l)) q[l*8 +: 8] <= wdata_i;
        end
      end
    end
    assign words[r] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_i == 2'(l)) rdata_o = words[idx_i][l*8 +: 8];
    end
  end
endmodule

// File: rtl/cop_suspend_timer.sv
`timescale 1ns/1ps
module cop_suspend_timer #(
  parameter int STEP = 32,
  parameter int KW   = 3,
  localparam int CW  = $clog2(STEP * (2 ** KW))
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [KW-1:0] arm_k_i,
  input  logic          cancel_i,
  output logic          active_o
);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (arm_i) begin
      act_q <= 1'b1;
      cnt_q <= CW'(arm_k_i) * CW'(STEP);
    end else if (cancel_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q && cnt_q != '0) begin
      // zero length: hold until cancelled
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/cop_data_ram.sv
`timescale 1ns/1ps
module cop_data_ram #(
  parameter int DEPTH = 3072,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rd_q <= mem[addr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/cop_host_regs.sv
`timescale 1ns/1ps
module cop_host_regs
  import cop_host_pkg::*;
#(
  parameter int HOST_AW    = 24,
  parameter int DRAM_DEPTH = 3072,
  parameter int GPR_N      = 16,
  parameter int GPR_W      = 24,
  parameter int VEC_N      = 32,
  parameter int SUSP_STEP  = 32,
  parameter int XA_W       = 24,
  parameter int LEN_W      = 16,
  parameter int BANK_W     = 15,
  parameter int PC_W       = 8,
  parameter int DLY_W      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic               dma_busy_i,
  input  logic               cache_busy_i,
  input  logic               bus_busy_i,
  input  logic               core_halt_i,
  input  logic               lock_req_i,
  input  logic               irq_set_i,
  output logic [XA_W-1:0]    dma_src_o,
  output logic [LEN_W-1:0]   dma_len_o,
  output logic [XA_W-1:0]    dma_dst_o,
  output logic [XA_W-1:0]    cache_base_o,
  output logic               cache_page_o,
  output logic [1:0]         cache_lock_o,
  output logic [BANK_W-1:0]  prog_bank_o,
  output logic [PC_W-1:0]    prog_ctr_o,
  output logic [DLY_W-1:0]   ram_dly_o,
  output logic [DLY_W-1:0]   rom_dly_o,
  output logic               irq_dis_o,
  output logic               single_rom_o,
  output logic               stopped_o,
  output logic               locked_o,
  output logic               suspend_o,
  output logic               irq_flag_o,
  output logic               dma_start_o,
  output logic               cache_start_o,
  output logic               exec_start_o
);
  localparam int GIW   = $clog2(GPR_N);
  localparam int VIW   = $clog2(VEC_N);
  localparam int DAW   = $clog2(DRAM_DEPTH);
  localparam int BHI_W = BANK_W - 8;

  logic [11:0]    off;
  region_e        region;
  logic [GIW-1:0] gpr_idx;
  logic [1:0]     gpr_lane;
  logic [VIW-1:0] vec_idx;
  logic [7:0]     gpr_rd, ram_rd, status, rd_d, rd_q;
  logic           ram_sel_q;
  logic           wr_ctrl, wr_stat, busy, running;
  logic           arm, cancel;

  assign off = addr_i[11:0];

  cop_addr_decode #(.DRAM_DEPTH(DRAM_DEPTH), .GPR_N(GPR_N), .VEC_N(VEC_N)) u_dec (
    .off_i(off), .region_o(region), .gpr_idx_o(gpr_idx),
    .gpr_lane_o(gpr_lane), .vec_idx_o(vec_idx)
  );

  cop_gpr_file #(.GPR_N(GPR_N), .GPR_W(GPR_W)) u_gpr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i && region == RG_GPR),
    .idx_i(gpr_idx), .lane_i(gpr_lane), .wdata_i(wdata_i), .rdata_o(gpr_rd)
  );

  cop_data_ram #(.DEPTH(DRAM_DEPTH)) u_ram (
    .clk_i(clk_i), .we_i(wr_en_i && region == RG_DRAM),
    .re_i(rd_en_i && region == RG_DRAM), .addr_i(off[DAW-1:0]),
    .wdata_i(wdata_i), .rdata_o(ram_rd)
  );

  assign wr_ctrl = wr_en_i && region == RG_CTRL;
  assign wr_stat = wr_en_i && region == RG_STAT;
  assign arm     = wr_stat && off >= OFF_ARM_LO && off <= OFF_ARM_HI;
  assign cancel  = wr_stat && off == OFF_CANCEL;

  cop_suspend_timer #(.STEP(SUSP_STEP), .KW(3)) u_susp (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm),
    .arm_k_i(3'(off - OFF_ARM_LO)), .cancel_i(cancel), .active_o(suspend_o)
  );

  // vector area
  logic [7:0] vec_q [VEC_N];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < VEC_N; i++) vec_q[i] <= '0;
    end else if (wr_en_i && region == RG_VEC) begin
      vec_q[vec_idx] <= wdata_i;
    end
  end

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_src_o    <= '0;
      dma_len_o    <= '0;
      dma_dst_o    <= '0;
      cache_base_o <= '0;
      cache_page_o <= 1'b0;
      cache_lock_o <= '0;
      prog_bank_o  <= '0;
      prog_ctr_o   <= '0;
      ram_dly_o    <= DLY_W'(WAIT_RESET);
      rom_dly_o    <= DLY_W'(WAIT_RESET);
      irq_dis_o    <= 1'b0;
      single_rom_o <= 1'b1;
    end else if (wr_ctrl) begin
      case (off)
        OFF_SRC0:   dma_src_o[7:0]      <= wdata_i;
        OFF_SRC1:   dma_src_o[15:8]     <= wdata_i;
        OFF_SRC2:   dma_src_o[23:16]    <= wdata_i;
        OFF_LEN0:   dma_len_o[7:0]      <= wdata_i;
        OFF_LEN1:   dma_len_o[15:8]     <= wdata_i;
        OFF_DST0:   dma_dst_o[7:0]      <= wdata_i;
        OFF_DST1:   dma_dst_o[15:8]     <= wdata_i;
        OFF_DST2:   dma_dst_o[23:16]    <= wdata_i;
        OFF_PAGE:   cache_page_o        <= wdata_i[0];
        OFF_CBASE0: cache_base_o[7:0]   <= wdata_i;
        OFF_CBASE1: cache_base_o[15:8]  <= wdata_i;
        OFF_CBASE2: cache_base_o[23:16] <= wdata_i;
        OFF_LOCK:   cache_lock_o        <= wdata_i[1:0];
        OFF_BANK0:  prog_bank_o[7:0]    <= wdata_i;
        OFF_BANK1:  prog_bank_o[BANK_W-1:8] <= wdata_i[BHI_W-1:0];
        OFF_PC:     prog_ctr_o          <= wdata_i[PC_W-1:0];
        OFF_WAIT: begin
          ram_dly_o <= wdata_i[DLY_W-1:0];
          rom_dly_o <= wdata_i[4 +: DLY_W];
        end
        OFF_IRQDIS: irq_dis_o    <= wdata_i[0];
        OFF_SROM:   single_rom_o <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // run state, lock, interrupt flag, strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stopped_o     <= 1'b1;
      locked_o      <= 1'b0;
      irq_flag_o    <= 1'b0;
      dma_start_o   <= 1'b0;
      cache_start_o <= 1'b0;
      exec_start_o  <= 1'b0;
    end else begin
      dma_start_o   <= wr_ctrl && off == OFF_DST2 && stopped_o;
      cache_start_o <= wr_ctrl && off == OFF_PAGE && stopped_o;
      exec_start_o  <= wr_ctrl && off == OFF_PC && stopped_o;

      if (wr_stat && off == OFF_UNLOCK)              stopped_o <= 1'b1;
      else if (wr_ctrl && off == OFF_PC && stopped_o) stopped_o <= 1'b0;
      else if (core_halt_i)                          stopped_o <= 1'b1;

      if (wr_stat && off == OFF_UNLOCK) locked_o <= 1'b0;
      else if (lock_req_i)              locked_o <= 1'b1;

      if (irq_set_i || (wr_ctrl && off == OFF_IRQDIS && wdata_i[0])) irq_flag_o <= 1'b1;
      else if (wr_stat && off == OFF_IRQCLR)                          irq_flag_o <= 1'b0;
    end
  end

  assign busy    = dma_busy_i | cache_busy_i | bus_busy_i;
  assign running = busy | ~stopped_o;
  assign status  = {busy, running, 4'b0000, irq_flag_o, suspend_o};

  always_comb begin
    rd_d = '0;
    case (region)
      RG_VEC:  rd_d = vec_q[vec_idx];
      RG_GPR:  rd_d = gpr_rd;
      RG_STAT: rd_d = status;
      RG_CTRL: begin
        case (off)
          OFF_SRC0:   rd_d = dma_src_o[7:0];
          OFF_SRC1:   rd_d = dma_src_o[15:8];
          OFF_SRC2:   rd_d = dma_src_o[23:16];
          OFF_LEN0:   rd_d = dma_len_o[7:0];
          OFF_LEN1:   rd_d = dma_len_o[15:8];
          OFF_DST0:   rd_d = dma_dst_o[7:0];
          OFF_DST1:   rd_d = dma_dst_o[15:8];
          OFF_DST2:   rd_d = dma_dst_o[23:16];
          OFF_PAGE:   rd_d = {7'b0, cache_page_o};
          OFF_CBASE0: rd_d = cache_base_o[7:0];
          OFF_CBASE1: rd_d = cache_base_o[15:8];
          OFF_CBASE2: rd_d = cache_base_o[23:16];
          OFF_LOCK:   rd_d = {6'b0, cache_lock_o};
          OFF_BANK0:  rd_d = prog_bank_o[7:0];
          OFF_BANK1:  rd_d = 8'(prog_bank_o[BANK_W-1:8]);
          OFF_PC:     rd_d = 8'(prog_ctr_o);
          OFF_WAIT:   rd_d = {1'b0, rom_dly_o, 1'b0, ram_dly_o};
          OFF_IRQDIS: rd_d = {7'b0, irq_dis_o};
          OFF_SROM:   rd_d = {7'b0, single_rom_o};
          default:    rd_d = '0;
        endcase
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= '0;
      ram_sel_q <= 1'b0;
    end else if (rd_en_i) begin
      rd_q      <= rd_d;
      ram_sel_q <= region == RG_DRAM;
    end
  end

  assign rdata_o = ram_sel_q ? ram_rd : rd_q;
endmodule

// File: rtl/cop_host_regs_chk.sv
`timescale 1ns/1ps
module cop_host_regs_chk #(
  parameter int HOST_AW = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [HOST_AW-1:0] addr_i,
  input logic [7:0]         wdata_i,
  input logic [7:0]         rdata_o,
  input logic               dma_busy_i,
  input logic               cache_busy_i,
  input logic               bus_busy_i,
  input logic               stopped_o,
  input logic               locked_o,
  input logic               suspend_o,
  input logic               irq_flag_o,
  input logic               dma_start_o,
  input logic               exec_start_o
);
  logic [11:0] off;
  assign off = addr_i[11:0];

  p_dma_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_start_o |-> $past(stopped_o));

  p_exec_clears_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> !stopped_o);

  p_unlock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off == 12'hF53) |=> (stopped_o && !locked_o));

  p_irq_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off == 12'hF51 && wdata_i[0]) |=> irq_flag_o);

  p_cancel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off == 12'hF5D) |=> !suspend_o);

  p_arm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off >= 12'hF55 && off <= 12'hF5C) |=> suspend_o);

  p_busy_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && off >= 12'hF53 && off <= 12'hF5F)
      |=> (rdata_o[7] == $past(dma_busy_i | cache_busy_i | bus_busy_i)));
endmodule

bind cop_host_regs cop_host_regs_chk #(.HOST_AW(HOST_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .dma_busy_i(dma_busy_i), .cache_busy_i(cache_busy_i), .bus_busy_i(bus_busy_i),
  .stopped_o(stopped_o), .locked_o(locked_o), .suspend_o(suspend_o),
  .irq_flag_o(irq_flag_o), .dma_start_o(dma_start_o), .exec_start_o(exec_start_o)
);

// File: tb/cop_host_regs_bench.sv
`timescale 1ns/1ps
module cop_host_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        dma_busy = 0, cache_busy = 0, bus_busy = 0;
  logic        core_halt = 0, lock_req = 0, irq_set = 0;
  logic [23:0] dma_src, dma_dst, cache_base;
  logic [15:0] dma_len;
  logic        cache_page;
  logic [1:0]  cache_lock;
  logic [14:0] prog_bank;
  logic [7:0]  prog_ctr;
  logic [2:0]  ram_dly, rom_dly;
  logic        irq_dis, single_rom, stopped, locked, suspend, irq_flag;
  logic        dma_start, cache_start, exec_start;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cop_host_regs u_cop_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .dma_busy_i(dma_busy), .cache_busy_i(cache_busy), .bus_busy_i(bus_busy),
    .core_halt_i(core_halt), .lock_req_i(lock_req), .irq_set_i(irq_set),
    .dma_src_o(dma_src), .dma_len_o(dma_len), .dma_dst_o(dma_dst),
    .cache_base_o(cache_base), .cache_page_o(cache_page), .cache_lock_o(cache_lock),
    .prog_bank_o(prog_bank), .prog_ctr_o(prog_ctr), .ram_dly_o(ram_dly),
    .rom_dly_o(rom_dly), .irq_dis_o(irq_dis), .single_rom_o(single_rom),
    .stopped_o(stopped), .locked_o(locked), .suspend_o(suspend),
    .irq_flag_o(irq_flag), .dma_start_o(dma_start), .cache_start_o(cache_start),
    .exec_start_o(exec_start)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  function automatic logic [7:0] stat_exp(input bit b, input bit s, input bit irq, input bit sus);
    return {b, b | ~s, 4'b0, irq, sus};
  endfunction

  logic [23:0] gpr_m [16];
  logic [7:0]  vec_m [32];
  logic [7:0]  ram_m [3072];
  bit          ram_v [3072];

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'h5EED_0C4));
    for (int i = 0; i < 16; i++) gpr_m[i] = '0;
    for (int i = 0; i < 32; i++) vec_m[i] = '0;
    for (int i = 0; i < 3072; i++) ram_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    chk("R10 reset stopped", stopped, 1);
    chk("R10 reset locked", locked, 0);
    rd(24'h007F52, d); chk("R10 reset single_rom", d, 8'h01);
    rd(24'h007F50, d); chk("R7 reset wait", d, 8'h33);
    rd(24'h007F55, d); chk("R4 reset status", d, 8'h00);
    rd(24'h007F65, d); chk("R2 reset vector", d, 8'h00);
    rd(24'h007F85, d); chk("R3 reset gpr", d, 8'h00);

    // R7 wait states
    wr(24'h007F50, 8'hF5);
    rd(24'h007F50, d); chk("R7 wait readback", d, 8'h75);
    chk("R7 ram_dly", ram_dly, 3'd5);
    chk("R7 rom_dly", rom_dly, 3'd7);

    // R1 folding and RAM
    wr(24'h123456, 8'hA7);
    rd(24'hAB7456, d); chk("R1 fold ram", d, 8'hA7);
    wr(24'h000BFF, 8'h3C);
    rd(24'h000BFF, d); chk("R1 ram top", d, 8'h3C);

    // R11 unmapped
    wr(24'h000C00, 8'hAA);
    rd(24'h000C00, d); chk("R11 unmapped C00", d, 8'h00);
    wr(24'h007FB5, 8'h55);
    rd(24'h007FB5, d); chk("R11 unmapped FB5", d, 8'h00);
    wr(24'h007FF3, 8'h55);
    rd(24'h007FF3, d); chk("R11 unmapped FF3", d, 8'h00);
    rd(24'h007F85, d); chk("R11 gpr untouched", d, 8'h00);
    wr(24'h007F54, 8'hFF);
    chk("R11 F54 no suspend", suspend, 0);
    chk("R11 F54 still stopped", stopped, 1);

    // R12 control readback
    wr(24'h007F40, 8'h11); wr(24'h007F41, 8'h22); wr(24'h007F42, 8'h33);
    chk("R12 dma_src", dma_src, 24'h332211);
    wr(24'h007F43, 8'h44); wr(24'h007F44, 8'h55);
    chk("R12 dma_len", dma_len, 16'h5544);
    rd(24'h007F44, d); chk("R12 len hi", d, 8'h55);
    wr(24'h007F49, 8'h9A); wr(24'h007F4A, 8'hBC); wr(24'h007F4B, 8'hDE);
    chk("R12 cache_base", cache_base, 24'hDEBC9A);
    rd(24'h007F4A, d); chk("R12 cbase mid", d, 8'hBC);
    wr(24'h007F4C, 8'hFE);
    rd(24'h007F4C, d); chk("R12 lock bits", d, 8'h02);
    wr(24'h007F52, 8'h00);
    chk("R12 single_rom clear", single_rom, 0);

    // R9 bank high
    wr(24'h007F4D, 8'h81); wr(24'h007F4E, 8'hFF);
    rd(24'h007F4E, d); chk("R9 bank hi 7 bits", d, 8'h7F);
    chk("R9 prog_bank", prog_bank, 15'h7F81);

    // R8 start strobes while stopped
    wr(24'h007F45, 8'h01); chk("R8 no start on DST0", dma_start, 0);
    wr(24'h007F46, 8'h02);
    wr(24'h007F47, 8'h03);
    chk("R8 dma_start", dma_start, 1);
    chk("R12 dma_dst", dma_dst, 24'h030201);
    @(negedge clk); chk("R8 dma_start one cycle", dma_start, 0);
    wr(24'h007F48, 8'h03);
    chk("R8 cache_start", cache_start, 1);
    chk("R8 page bit", cache_page, 1);
    wr(24'h007F4F, 8'h42);
    chk("R8 exec_start", exec_start, 1);
    chk("R8 stopped cleared", stopped, 0);
    chk("R8 pc", prog_ctr, 8'h42);
    rd(24'h007F53, d); chk("R4 running bit", d, stat_exp(0, 0, 0, 0));
    // gated while running
    wr(24'h007F47, 8'h07); chk("R8 dma gated", dma_start, 0);
    wr(24'h007F48, 8'h00); chk("R8 cache gated", cache_start, 0);
    chk("R8 page updates anyway", cache_page, 0);
    wr(24'h007F4F, 8'h10); chk("R8 exec gated", exec_start, 0);

    // R10 halt, lock, unlock
    @(negedge clk); core_halt = 1; @(negedge clk); core_halt = 0;
    chk("R10 core halt", stopped, 1);
    @(negedge clk); lock_req = 1; @(negedge clk); lock_req = 0;
    chk("R10 locked", locked, 1);
    wr(24'h007F4F, 8'h20);
    chk("R10 running again", stopped, 0);
    @(negedge clk); wr_en = 1; addr = 24'h007F53; lock_req = 1;
    @(negedge clk); wr_en = 0; lock_req = 0;
    chk("R10 unlock wins", locked, 0);
    chk("R10 unlock stops", stopped, 1);

    // R4 busy bits and R9/R6 irq
    dma_busy = 1;
    rd(24'h007F5A, d); chk("R4 busy dma", d, stat_exp(1, 1, 0, 0));
    dma_busy = 0; bus_busy = 1;
    rd(24'h007F5F, d); chk("R4 busy bus", d, stat_exp(1, 1, 0, 0));
    bus_busy = 0; cache_busy = 1;
    wr(24'h007F51, 8'h01);
    chk("R9 irq forced", irq_flag, 1);
    rd(24'h007F51, d); chk("R12 irq dis readback", d, 8'h01);
    rd(24'h007F53, d); chk("R4 irq bit", d, stat_exp(1, 1, 1, 0));
    cache_busy = 0;
    wr(24'h007F5E, 8'h00); chk("R6 irq clear", irq_flag, 0);
    wr(24'h007F51, 8'h00); chk("R9 dis=0 no set", irq_flag, 0);
    @(negedge clk); wr_en = 1; addr = 24'h007F5E; irq_set = 1;
    @(negedge clk); wr_en = 0; irq_set = 0;
    chk("R6 set beats clear", irq_flag, 1);
    wr(24'h007F5E, 8'h00);

    // R5 suspend timing, k=1 and k=3
    wr(24'h007F56, 8'h00);
    chk("R5 k1 armed", suspend, 1);
    rd(24'h007F54, d); chk("R4 suspend bit", d, stat_exp(0, 1, 0, 1));
    repeat (29) @(negedge clk);
    chk("R5 k1 last cycle", suspend, 1);
    @(negedge clk); chk("R5 k1 expired", suspend, 0);
    wr(24'h007F58, 8'h00);
    repeat (95) @(negedge clk);
    chk("R5 k3 last cycle", suspend, 1);
    @(negedge clk); chk("R5 k3 expired", suspend, 0);
    // k=0 holds until cancel
    wr(24'h007F55, 8'h00);
    repeat (300) @(negedge clk);
    chk("R5 k0 holds", suspend, 1);
    wr(24'h007F5D, 8'h00); chk("R6 cancel", suspend, 0);
    wr(24'h007F5C, 8'h00);
    wr(24'h007F5D, 8'h00); chk("R6 cancel k7", suspend, 0);

    // R3 aliasing directed
    wr(24'h007F80, 8'h01); wr(24'h007F81, 8'h02); wr(24'h007F82, 8'h03);
    gpr_m[0] = 24'h030201;
    rd(24'h007FC1, d); chk("R3 alias lane1", d, 8'h02);
    wr(24'h007FEF, 8'hEE); gpr_m[15][23:16] = 8'hEE;
    rd(24'h007FAF, d); chk("R3 reg15 lane2", d, 8'hEE);

    // random mix for R1 R2 R3
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom % 3;
      bit do_wr = $urandom % 2;
      logic [7:0] v = 8'($urandom);
      logic [11:0] hi = 12'($urandom);
      if (sel == 0) begin
        int o = $urandom % 48;
        logic [11:0] of = (($urandom % 2) ? 12'hF80 : 12'hFC0) + 12'(o);
        if (do_wr) begin
          wr({hi, of}, v);
          gpr_m[o/3][(o%3)*8 +: 8] = v;
        end else begin
          rd({hi, of}, d); chk("R3 random gpr", d, 32'(gpr_m[o/3][(o%3)*8 +: 8]));
        end
      end else if (sel == 1) begin
        int o = $urandom % 32;
        if (do_wr) begin
          wr({hi, 12'hF60 + 12'(o)}, v); vec_m[o] = v;
        end else begin
          rd({hi, 12'hF60 + 12'(o)}, d); chk("R2 random vector", d, 32'(vec_m[o]));
        end
      end else begin
        int o = $urandom % 3072;
        if (do_wr || !ram_v[o]) begin
          wr({hi, 12'(o)}, v); ram_m[o] = v; ram_v[o] = 1;
        end else begin
          rd({hi, 12'(o)}, d); chk("R1 random ram", d, 32'(ram_m[o]));
        end
      end
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule